// File: doc/BRIEF.md
# I/Q to Polar Envelope and Phase Converter

This block turns a stream of signed baseband in-phase and quadrature samples into an envelope magnitude and a phase angle. A polar transmitter uses the two results to drive its amplitude path and its digital phase modulator. The block accepts one sample per clock and returns one result per clock after a fixed latency. A valid flag qualifies every input and every output.

The converter is a vectoring CORDIC in which every iteration has its own pipeline stage. An input stage first folds any left-half-plane vector into the right half-plane. It does this with a swap of the two coordinates and one negation, and it presets the angle accumulator to plus or minus one half turn of pi. The micro-rotation stages then use a modified recurrence. The y residual is kept multiplied by 2^k and is doubled at every stage. Its precision therefore holds as it shrinks, and the x update needs a right shift of 2k. A final stage multiplies x by a precomputed constant that removes the CORDIC gain.

Phase is a signed fraction of pi. Envelope is an unsigned fixed-point value with two fractional bits, so one input LSB of magnitude equals 4 envelope codes.

Top module: `iq_to_polar`

## Requirements
- R1: For every valid input (I, Q), out_env equals round(4·sqrt(I²+Q²)), within ±3 codes.
- R2: out_phase is a 16-bit two's complement code for atan2(Q, I)·32768/π. Code −32768 stands for −π and 16384 for +π/2. It lies within ±4 codes of the ideal value, compared modulo 65536, whenever the input magnitude is at least 16.
- R3: out_valid rises exactly 16 clocks after the clock edge that captured in_valid high. Inputs on consecutive clocks produce results on consecutive clocks, in input order.
- R4: Vectors with negative I, including those on the negative real axis and near ±π, meet R1 and R2. The result may wrap between +π and −π.
- R5: An input with I = Q = 0 yields out_env = 0 and outputs free of unknown values.
- R6: Full-scale inputs, including I = Q = −2048, do not overflow. out_env never exceeds 11601.
- R7: rst is synchronous and active high. While it is asserted and on the following clock, out_valid is 0, and samples in flight when rst is asserted never produce a result.
- R8: A clock with in_valid low produces no result. The number of results equals the number of accepted samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | 12 | In-phase sample, two's complement |
| in_q | input | 12 | Quadrature sample, two's complement |
| out_valid | output | 1 | Result qualifier |
| out_env | output | 14 | Envelope, unsigned, 2 fractional bits |
| out_phase | output | 16 | Phase, signed fraction of pi |

## Verification
Two things can happen on the same clock: a new sample enters the fold stage while an older result leaves the gain stage. Across the pipeline, up to sixteen vectors from different quadrants are in flight at once. The bench provokes this with long back-to-back bursts that mix the axes, the diagonals, the zero vector and random vectors. It breaks the bursts with idle gaps and with a reset in mid-flight. Each result is judged against a queued real-valued expectation that holds its own capture cycle, so a result from the wrong sample, a lost slot or a shifted latency shows up as an envelope, phase or latency mismatch.

// File: rtl/iq_to_polar_pkg.sv
package iq_to_polar_pkg;

  localparam real PI_VAL = 3.14159265358979323846;

  // angle of micro-rotation k, in units of pi scaled by 2^(zw-1)
  function automatic int angle_code(input int k, input int zw);
    real a;
    a = $atan(2.0 ** (-k)) / PI_VAL * (2.0 ** (zw - 1));
    return $rtoi(a + 0.5);
  endfunction

  // reciprocal of the accumulated CORDIC gain, scaled by 2^kf
  function automatic int inv_gain_code(input int ns, input int kf);
    real g;
    g = 1.0;
    for (int k = 0; k < ns; k++) g = g * $sqrt(1.0 + 2.0 ** (-2 * k));
    return $rtoi((2.0 ** kf) / g + 0.5);
  endfunction

endpackage

// File: rtl/iq_to_polar_fold.sv
module iq_to_polar_fold #(
  parameter int IW = 12,
  parameter int DW = 22,
  parameter int ZW = 18,
  parameter int G  = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [IW-1:0]        in_i,
  input  logic [IW-1:0]        in_q,
  output logic                 out_valid,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] w_o,
  output logic signed [ZW-1:0] z_o
);
  localparam logic signed [ZW-1:0] HALF_TURN = ZW'(1) <<< (ZW - 2);

  logic signed [DW-1:0] xi, yi;
  assign xi = $signed({{(DW-IW){in_i[IW-1]}}, in_i}) <<< G;
  assign yi = $signed({{(DW-IW){in_q[IW-1]}}, in_q}) <<< G;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (!in_i[IW-1]) begin
      x_o <= xi;
      w_o <= yi;
      z_o <= '0;
    end else if (!in_q[IW-1]) begin
      // second quadrant: turn by -90 degrees
      x_o <= yi;
      w_o <= -xi;
      z_o <= HALF_TURN;
    end else begin
      // third quadrant: turn by +90 degrees
      x_o <= -yi;
      w_o <= xi;
      z_o <= -HALF_TURN;
    end
  end
endmodule

// File: rtl/iq_to_polar_stage.sv
module iq_to_polar_stage
  import iq_to_polar_pkg::*;
#(
  parameter int DW = 22,
  parameter int ZW = 18,
  parameter int K  = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] w_i,
  input  logic signed [ZW-1:0] z_i,
  output logic                 out_valid,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] w_o,
  output logic signed [ZW-1:0] z_o
);
  localparam logic signed [ZW-1:0] STEP = ZW'(angle_code(K, ZW));
  localparam int SH = 2 * K;

  logic signed [DW-1:0] w_shift;
  logic                 pos;

  // w holds y scaled by 2^K, so the x update shifts by 2K
  generate
    if (SH >= DW) begin : g_wide
      assign w_shift = {DW{w_i[DW-1]}};
    end else begin : g_shift
      assign w_shift = w_i >>> SH;
    end
  endgenerate

  assign pos = ~w_i[DW-1];

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (pos) begin
      x_o <= x_i + w_shift;
      w_o <= (w_i - x_i) <<< 1;
      z_o <= z_i + STEP;
    end else begin
      x_o <= x_i - w_shift;
      w_o <= (w_i + x_i) <<< 1;
      z_o <= z_i - STEP;
    end
  end
endmodule

// File: rtl/iq_to_polar_gain.sv
module iq_to_polar_gain
  import iq_to_polar_pkg::*;
#(
  parameter int DW = 22,
  parameter int ZW = 18,
  parameter int PW = 16,
  parameter int EW = 14,
  parameter int NS = 14,
  parameter int KF = 16,
  parameter int G  = 6,
  parameter int EF = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [ZW-1:0] z_i,
  output logic                 out_valid,
  output logic [EW-1:0]        env_o,
  output logic [PW-1:0]        phase_o
);
  localparam int PRW = DW + KF + 2;
  localparam int SH  = KF + G - EF;
  localparam logic signed [KF+1:0] KINV = (KF+2)'(inv_gain_code(NS, KF));
  localparam logic signed [PRW-1:0] RND = PRW'(1) <<< (SH - 1);
  localparam logic signed [PRW-1:0] EMAX = PRW'((1 << EW) - 1);

  logic signed [PRW-1:0] prod, scaled;

  assign prod   = PRW'(x_i) * PRW'(KINV);
  assign scaled = (prod + RND) >>> SH;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (scaled < 0)         env_o <= '0;
    else if (scaled > EMAX) env_o <= '1;
    else                    env_o <= scaled[EW-1:0];
    phase_o <= z_i[ZW-1 -: PW];
  end
endmodule

// File: rtl/iq_to_polar.sv
module iq_to_polar #(
  parameter int IW = 12,
  parameter int PW = 16,
  parameter int EW = 14,
  parameter int NS = 14,
  parameter int G  = 6,
  parameter int ZG = 2,
  parameter int KF = 16,
  parameter int EF = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [IW-1:0] in_i,
  input  logic [IW-1:0] in_q,
  output logic          out_valid,
  output logic [EW-1:0] out_env,
  output logic [PW-1:0] out_phase
);
  localparam int DW = IW + G + 4;
  localparam int ZW = PW + ZG;

  logic                 vs [NS+1];
  logic signed [DW-1:0] xs [NS+1];
  logic signed [DW-1:0] ws [NS+1];
  logic signed [ZW-1:0] zs [NS+1];

  iq_to_polar_fold #(.IW(IW), .DW(DW), .ZW(ZW), .G(G)) u_fold (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(vs[0]), .x_o(xs[0]), .w_o(ws[0]), .z_o(zs[0])
  );

  generate
    for (genvar k = 0; k < NS; k++) begin : g_iter
      iq_to_polar_stage #(.DW(DW), .ZW(ZW), .K(k)) u_stage (
        .clk(clk), .rst(rst), .in_valid(vs[k]),
        .x_i(xs[k]), .w_i(ws[k]), .z_i(zs[k]),
        .out_valid(vs[k+1]), .x_o(xs[k+1]), .w_o(ws[k+1]), .z_o(zs[k+1])
      );
    end
  endgenerate

  iq_to_polar_gain #(.DW(DW), .ZW(ZW), .PW(PW), .EW(EW), .NS(NS),
                     .KF(KF), .G(G), .EF(EF)) u_gain (
    .clk(clk), .rst(rst), .in_valid(vs[NS]), .x_i(xs[NS]), .z_i(zs[NS]),
    .out_valid(out_valid), .env_o(out_env), .phase_o(out_phase)
  );
endmodule

// File: rtl/iq_to_polar_chk.sv
module iq_to_polar_chk #(
  parameter int IW = 12,
  parameter int PW = 16,
  parameter int EW = 14,
  parameter int NS = 14,
  parameter int EF = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [IW-1:0] in_i,
  input logic [IW-1:0] in_q,
  input logic          out_valid,
  input logic [EW-1:0] out_env,
  input logic [PW-1:0] out_phase
);
  localparam int LAT = NS + 2;
  localparam int ENV_CEIL = $rtoi(1.41422 * (2.0 ** (IW - 1 + EF))) + 16;

  logic [LAT-1:0] vsr, zsr;

  always_ff @(posedge clk) begin
    if (rst) begin
      vsr <= '0;
      zsr <= '0;
    end else begin
      vsr <= {vsr[LAT-2:0], in_valid};
      zsr <= {zsr[LAT-2:0], in_valid && (in_i == '0) && (in_q == '0)};
    end
  end

  // R3, R8: a result appears exactly LAT clocks after each accepted sample
  a_r3_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid == vsr[LAT-1]);

  // R5: zero vector gives zero envelope
  a_r5_zero_env: assert property (@(posedge clk) disable iff (rst)
    (out_valid && zsr[LAT-1]) |-> (out_env == '0));

  // R5: no unknown values on a valid result
  a_r5_known: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !$isunknown({out_env, out_phase}));

  // R6: envelope stays under the full-scale ceiling
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(out_env) <= ENV_CEIL));

  // R7: reset clears the output qualifier on the next clock
  a_r7_reset_clear: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind iq_to_polar iq_to_polar_chk #(.IW(IW), .PW(PW), .EW(EW), .NS(NS), .EF(EF)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
  .out_valid(out_valid), .out_env(out_env), .out_phase(out_phase)
);

// File: tb/iq_to_polar_bench.sv
`timescale 1ns/1ps
module iq_to_polar_bench;
  localparam int LAT = 16;
  localparam real PI_VAL = 3.14159265358979323846;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [11:0] in_i = '0;
  logic [11:0] in_q = '0;
  logic        out_valid;
  logic [13:0] out_env;
  logic [15:0] out_phase;

  iq_to_polar u_iq_to_polar (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_env(out_env), .out_phase(out_phase)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    real env;
    real ph;
    int  cyc;
    bit  chk_ph;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   n_tests = 0;
  int   n_fail = 0;
  int   n_in = 0;
  int   n_out = 0;
  bit   seen_out = 1'b0;
  bit   finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string msg);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic drive(input int i, input int q);
    exp_t e;
    real ph;
    @(negedge clk);
    in_valid = 1'b1;
    in_i = 12'(i);
    in_q = 12'(q);
    e.env = $sqrt(real'(i * i + q * q)) * 4.0;
    ph = (i == 0 && q == 0) ? 0.0 : $atan2(real'(q), real'(i)) / PI_VAL * 32768.0;
    e.ph = ph;
    e.cyc = cyc;
    e.chk_ph = (i * i + q * q) >= 256;
    sb.push_back(e);
    n_in++;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pop and compare
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      seen_out = 1'b1;
      n_out++;
      if (sb.size() == 0) begin
        check(1'b0, "R8", $sformatf("unexpected result env=%0d expected none", out_env));
      end else begin
        exp_t e;
        real de, dp;
        e = sb.pop_front();
        de = real'(out_env) - e.env;
        if (de < 0) de = -de;
        check(de <= 3.0, "R1", $sformatf("env actual %0d expected %0.2f", out_env, e.env));
        if (e.env == 0.0)
          check(out_env == 0 && !$isunknown(out_phase), "R5",
                $sformatf("zero vector env actual %0d expected 0", out_env));
        if (e.chk_ph) begin
          dp = real'($signed(out_phase)) - e.ph;
          while (dp > 32768.0) dp -= 65536.0;
          while (dp < -32768.0) dp += 65536.0;
          if (dp < 0) dp = -dp;
          check(dp <= 4.0, "R2", $sformatf("phase actual %0d expected %0.2f",
                $signed(out_phase), e.ph));
        end
        check(cyc - e.cyc == LAT, "R3", $sformatf("latency actual %0d expected %0d",
              cyc - e.cyc, LAT));
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", "run hung, actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7", $sformatf("out_valid in reset actual %0b expected 0", out_valid));
    rst = 1'b0;
    idle(2);
    check(out_valid == 1'b0, "R7", $sformatf("out_valid after reset actual %0b expected 0", out_valid));

    // axis-aligned and diagonal vectors, back to back (R1, R2, R4)
    drive(2047, 0);
    drive(0, 2047);
    drive(-2048, 0);   // negative real axis, R4
    drive(0, -2048);
    drive(1000, 1000);
    drive(-1000, 1000);
    drive(-1000, -1000);
    drive(1000, -1000);
    drive(-2048, 1);   // just below +pi, R4
    drive(-2048, -1);  // just above -pi, R4
    drive(0, 0);       // R5
    drive(-2048, -2048); // R6 full scale
    drive(2047, 2047);
    drive(-2048, 2047);
    drive(16, 0);
    drive(0, 0);
    drive(1, 0);
    idle(3);

    // random bursts with gaps (R8)
    for (int b = 0; b < 40; b++) begin
      for (int s = 0; s < 25; s++) begin
        int ri, rq;
        ri = int'($signed(12'($urandom)));
        rq = int'($signed(12'($urandom)));
        drive(ri, rq);
      end
      idle(1 + (b % 4));
    end
    idle(LAT + 4);
    check(sb.size() == 0, "R8", $sformatf("pending actual %0d expected 0", sb.size()));

    // reset in mid-flight (R7)
    for (int s = 0; s < 6; s++) drive(500 + s, -300);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    sb.delete();
    n_in = n_in - 6;
    idle(2);
    rst = 1'b0;
    seen_out = 1'b0;
    idle(LAT + 4);
    check(!seen_out, "R7", $sformatf("results after reset actual %0b expected 0", seen_out));

    // idle stream produces nothing (R8)
    idle(30);
    check(!seen_out, "R8", $sformatf("idle output actual %0b expected 0", seen_out));

    // post-reset traffic still correct
    drive(-1500, 700);
    drive(300, -1900);
    drive(0, 0);
    idle(LAT + 4);
    check(n_out == n_in, "R8", $sformatf("result count actual %0d expected %0d", n_out, n_in));
    check(sb.size() == 0, "R3", $sformatf("pending actual %0d expected 0", sb.size()));

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule